// File: doc/BRIEF.md
# LIN Slave Error Detector

This block sits next to the frame controller of a LIN slave node and turns its per-bit and per-byte strobes into seven sticky error flags. It compares the level the node drives against the level read back from the bus. It checks stop bits, the sync byte after a long break, and the two parity bits of the identifier byte. It times the whole frame against a length that depends on the response size and the checksum model. It also records failed checksum tests and responses that were not prepared in time.

When an enabled error calls for it, the block issues a one-cycle cancel request to the frame controller. The cycle of that request depends on the kind of error and on where a bit error happened. Software reads the flags and clears each one by writing 1 to its bit. The interrupt line is high while any flag is set. Bit timing, byte assembly and checksum arithmetic stay in the frame controller.

Top module: `lin_err_monitor`

## Requirements
- R1: Flag positions are bit error 0, timeout 1, framing 2, sync 3, checksum 4, identifier parity 5, response preparation 6. All flags and the cancel output are 0 after reset, and `irq` is 1 exactly while any flag is 1.
- R2: The phase input is coded idle 0, break 1, sync 2, identifier 3, data 4, stop 5, gap 6, wake 7. With `tx_active` high and `bit_stb` high in phase data, stop, gap or wake, a difference between `tx_bit` and `rx_bit` sets flag 0 in the next cycle, provided `err_en[0]` is 1.
- R3: A bit error in phase data raises no cancel at once. The cancel pulse comes in the cycle after the next transmitted stop-bit strobe.
- R4: A bit error in phase gap or wake raises a one-cycle cancel in the cycle after the erroneous bit strobe.
- R5: In reception (`tx_active` low), a stop-phase bit strobe with `rx_bit` low sets flag 2. A high stop bit sets nothing.
- R6: A sync-phase `byte_stb` sets flag 3 only when `brk_len` is strictly greater than `brk_thr` and `rx_byte` differs from 0x55.
- R7: An identifier-phase `byte_stb` sets flag 5 when bit 6 of `rx_byte` differs from id0^id1^id2^id4, or bit 7 differs from the inverse of id1^id3^id4^id5, where id0..id5 are bits 0..5.
- R8: After `frame_start`, the bit strobe that brings the count to 49+(n+1)*14 (classic, `cks_enh`=0) or 48+(n+1)*14 (enhanced) sets flag 1. Here n is `dlen` limited to the maximum response length. `frame_end` stops the timer.
- R9: A `cks_stb` with `cks_ok` low sets flag 4 whatever `err_en` holds, and causes no cancel.
- R10: A `resp_start` with `resp_rdy` low sets flag 6 whatever `err_en` holds, and causes no cancel.
- R11: An enabled timeout, framing, sync or parity error gives a one-cycle cancel in the same cycle its flag rises. With its `err_en` bit at 0, an error of one of these kinds, or a bit error, sets no flag and causes no cancel.
- R12: A flag stays set until `err_clr` has 1 in its position. A new error in the same cycle as the clear wins, and clear bits of other positions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase | input | 3 | Current frame phase from the frame controller |
| bit_stb | input | 1 | One cycle per sampled bit |
| tx_active | input | 1 | Node is driving the bus in this phase |
| tx_bit | input | 1 | Level being transmitted |
| rx_bit | input | 1 | Level sampled on the bus |
| byte_stb | input | 1 | A received byte is complete in `rx_byte` |
| rx_byte | input | 8 | Last received byte |
| brk_len | input | BRK_W | Measured break low length |
| brk_thr | input | BRK_W | Programmed break length threshold |
| frame_start | input | 1 | Starts the frame timer |
| frame_end | input | 1 | Stops the frame timer |
| dlen | input | 4 | Response data length in bytes |
| cks_enh | input | 1 | Enhanced checksum model selected |
| cks_stb | input | 1 | Checksum test result valid |
| cks_ok | input | 1 | Checksum test passed |
| resp_start | input | 1 | First byte of a response data group begins |
| resp_rdy | input | 1 | Response data is prepared |
| err_en | input | 7 | Per-flag detection enable (bits 4 and 6 ignored) |
| err_clr | input | 7 | Write-1-to-clear strobes per flag |
| err_flags | output | 7 | Sticky error flags |
| cancel | output | 1 | One-cycle communication cancel request |
| irq | output | 1 | Interrupt, any flag set |

## Verification
The bench builds the block with a 5-bit break length and the default maximum of eight response bytes. The narrow break field puts the threshold comparison a single count from either side. The eight-byte limit keeps both timeout lengths short: 63 bit strobes for an empty classic frame and 90 for two bytes in the enhanced model. The bench can therefore run one frame to expiry and stop another just short of its limit.

// File: rtl/lin_err_pkg.sv
`timescale 1ns/1ps
package lin_err_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_BREAK = 3'd1,
      PH_SYNC  = 3'd2,
      PH_PID   = 3'd3,
      PH_DATA  = 3'd4,
      PH_STOP  = 3'd5,
      PH_GAP   = 3'd6,
      PH_WAKE  = 3'd7
   } lin_phase_e;

   localparam int NERR  = 7;
   localparam int E_BIT = 0;
   localparam int E_TMO = 1;
   localparam int E_FRM = 2;
   localparam int E_SYN = 3;
   localparam int E_CKS = 4;
   localparam int E_PAR = 5;
   localparam int E_RSP = 6;

   // flags that cannot be switched off
   localparam logic [NERR-1:0] ALWAYS_ON = 7'b1010000;
   // flags whose rise cancels communication at once (bit error handled apart)
   localparam logic [NERR-1:0] CUTS_NOW  = 7'b0101110;
endpackage

// File: rtl/lin_pid_check.sv
`timescale 1ns/1ps
module lin_pid_check (
   input  logic [7:0] pid,
   output logic       bad
);
   logic p0_calc, p1_calc;

   always_comb begin
      p0_calc = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
      p1_calc = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
      bad     = (pid[6] != p0_calc) || (pid[7] != p1_calc);
   end
endmodule

// File: rtl/lin_frame_timer.sv
`timescale 1ns/1ps
module lin_frame_timer #(
   parameter int NDATA_MAX = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_start,
   input  logic       frame_end,
   input  logic       bit_stb,
   input  logic [3:0] dlen,
   input  logic       enh,
   output logic       expire
);
   localparam int MAX_LIM = 49 + (NDATA_MAX + 1) * 14;
   localparam int CW      = $clog2(MAX_LIM + 1);

   if (NDATA_MAX < 1 || NDATA_MAX > 14) begin : g_bad_ndata
      $error("lin_frame_timer: NDATA_MAX out of range");
   end

   logic [3:0]    n_eff;
   logic [CW-1:0] limit;
   logic [CW-1:0] cnt;
   logic          run;

   always_comb begin
      n_eff  = (dlen > 4'(NDATA_MAX)) ? 4'(NDATA_MAX) : dlen;
      limit  = (enh ? CW'(48) : CW'(49)) + (CW'(n_eff) + CW'(1)) * CW'(14);
      expire = run && bit_stb && !frame_end && ((cnt + CW'(1)) >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (frame_start) begin
         run <= 1'b1;
         cnt <= '0;
      end else if (frame_end || expire) begin
         run <= 1'b0;
      end else if (run && bit_stb) begin
         cnt <= cnt + CW'(1);
      end
   end

   // R8: an end of frame always halts the timer
   p_end_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !frame_start) |=> !run);
endmodule

// File: rtl/lin_bit_guard.sv
`timescale 1ns/1ps
module lin_bit_guard
   import lin_err_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       bit_stb,
   input  lin_phase_e ph,
   input  logic       tx_active,
   input  logic       tx_bit,
   input  logic       rx_bit,
   input  logic       frame_start,
   output logic       hit,
   output logic       cut_q
);
   logic in_zone, at_stop, cut_now, pend;

   always_comb begin
      in_zone = (ph == PH_DATA) || (ph == PH_STOP) || (ph == PH_GAP) || (ph == PH_WAKE);
      hit     = en && bit_stb && tx_active && in_zone && (tx_bit != rx_bit);
      at_stop = bit_stb && tx_active && (ph == PH_STOP);
      cut_now = (hit && ((ph == PH_GAP) || (ph == PH_WAKE))) || (at_stop && (pend || hit));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         cut_q <= 1'b0;
      end else begin
         cut_q <= cut_now;
         if (frame_start || at_stop) pend <= 1'b0;
         else if (hit && ph == PH_DATA) pend <= 1'b1;
      end
   end

   // R3: a data-bit error never cancels in the very next cycle
   p_data_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ph == PH_DATA) |=> !cut_q);
   // R4: gap and wake errors cut straight after the bad bit
   p_gap_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (ph == PH_GAP || ph == PH_WAKE)) |=> cut_q);
endmodule

// File: rtl/lin_err_monitor.sv
`timescale 1ns/1ps
module lin_err_monitor
   import lin_err_pkg::*;
#(
   parameter int          BRK_W     = 8,
   parameter int          NDATA_MAX = 8,
   parameter logic [7:0]  SYNC_PAT  = 8'h55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       phase,
   input  logic             bit_stb,
   input  logic             tx_active,
   input  logic             tx_bit,
   input  logic             rx_bit,
   input  logic             byte_stb,
   input  logic [7:0]       rx_byte,
   input  logic [BRK_W-1:0] brk_len,
   input  logic [BRK_W-1:0] brk_thr,
   input  logic             frame_start,
   input  logic             frame_end,
   input  logic [3:0]       dlen,
   input  logic             cks_enh,
   input  logic             cks_stb,
   input  logic             cks_ok,
   input  logic             resp_start,
   input  logic             resp_rdy,
   input  logic [6:0]       err_en,
   input  logic [6:0]       err_clr,
   output logic [6:0]       err_flags,
   output logic             cancel,
   output logic             irq
);
   if (BRK_W < 2 || BRK_W > 16) begin : g_bad_brk
      $error("lin_err_monitor: BRK_W out of range");
   end

   lin_phase_e      ph;
   logic            bit_hit, bit_cut, tmo_hit, pid_bad;
   logic [NERR-1:0] set_raw, set_g, flag_q;
   logic            cut_q;

   assign ph = lin_phase_e'(phase);

   lin_bit_guard u_bit (
      .clk(clk), .rst_n(rst_n), .en(err_en[E_BIT]), .bit_stb(bit_stb), .ph(ph),
      .tx_active(tx_active), .tx_bit(tx_bit), .rx_bit(rx_bit),
      .frame_start(frame_start), .hit(bit_hit), .cut_q(bit_cut)
   );

   lin_frame_timer #(.NDATA_MAX(NDATA_MAX)) u_tmr (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
      .bit_stb(bit_stb), .dlen(dlen), .enh(cks_enh), .expire(tmo_hit)
   );

   lin_pid_check u_pid (.pid(rx_byte), .bad(pid_bad));

   always_comb begin
      set_raw        = '0;
      set_raw[E_BIT] = bit_hit;
      set_raw[E_TMO] = tmo_hit;
      set_raw[E_FRM] = bit_stb && !tx_active && (ph == PH_STOP) && !rx_bit;
      set_raw[E_SYN] = byte_stb && (ph == PH_SYNC) && (brk_len > brk_thr) && (rx_byte != SYNC_PAT);
      set_raw[E_CKS] = cks_stb && !cks_ok;
      set_raw[E_PAR] = byte_stb && (ph == PH_PID) && pid_bad;
      set_raw[E_RSP] = resp_start && !resp_rdy;
      set_g          = set_raw & (err_en | ALWAYS_ON);
   end

   for (genvar g = 0; g < NERR; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[g] <= 1'b0;
         else        flag_q[g] <= (flag_q[g] & ~err_clr[g]) | set_g[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cut_q <= 1'b0;
      else        cut_q <= |(set_g & CUTS_NOW);
   end

   assign err_flags = flag_q;
   assign cancel    = cut_q | bit_cut;
   assign irq       = |flag_q;

   // R12: no flag drops without its clear strobe
   p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(err_flags) & ~$past(err_clr)) & ~err_flags) == '0));
   // R9: failed checksum always lands in its flag
   p_cks_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cks_stb && !cks_ok) |=> err_flags[E_CKS]);
   // R10: late response preparation always lands in its flag
   p_rsp_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_start && !resp_rdy) |=> err_flags[E_RSP]);
endmodule

// File: tb/test_lin_err_monitor.sv
`timescale 1ns/1ps
module test_lin_err_monitor;
   localparam int BRK_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] phase;
   logic bit_stb, tx_active, tx_bit, rx_bit, byte_stb;
   logic [7:0] rx_byte;
   logic [BRK_W-1:0] brk_len, brk_thr;
   logic frame_start, frame_end, cks_enh, cks_stb, cks_ok, resp_start, resp_rdy;
   logic [3:0] dlen;
   logic [6:0] err_en, err_clr, err_flags;
   logic cancel, irq;

   always #10 clk = ~clk;

   lin_err_monitor #(.BRK_W(BRK_W), .NDATA_MAX(8)) i_lin_err_monitor (
      .clk(clk), .rst_n(rst_n), .phase(phase), .bit_stb(bit_stb), .tx_active(tx_active),
      .tx_bit(tx_bit), .rx_bit(rx_bit), .byte_stb(byte_stb), .rx_byte(rx_byte),
      .brk_len(brk_len), .brk_thr(brk_thr), .frame_start(frame_start), .frame_end(frame_end),
      .dlen(dlen), .cks_enh(cks_enh), .cks_stb(cks_stb), .cks_ok(cks_ok),
      .resp_start(resp_start), .resp_rdy(resp_rdy), .err_en(err_en), .err_clr(err_clr),
      .err_flags(err_flags), .cancel(cancel), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   int pcnt = 0;
   bit done = 0;
   logic [6:0] ef = '0;

   int         q_at[$];
   logic [6:0] q_f[$];
   logic       q_c[$];
   string      q_tag[$];

   localparam logic [2:0] P_IDLE = 3'd0, P_SYNC = 3'd2, P_PID = 3'd3, P_DATA = 3'd4,
                          P_STOP = 3'd5, P_GAP = 3'd6, P_WAKE = 3'd7;

   function automatic logic [7:0] pid_of(input logic [5:0] id);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0, id};
   endfunction

   task automatic expect_out(input logic [6:0] f, input logic c, input string tag);
      q_at.push_back(pcnt + 1);
      q_f.push_back(f);
      q_c.push_back(c);
      q_tag.push_back(tag);
   endtask

   task automatic quiet();
      bit_stb = 0; byte_stb = 0; frame_start = 0; frame_end = 0;
      cks_stb = 0; resp_start = 0; err_clr = '0;
   endtask

   task automatic fire();
      @(negedge clk);
      quiet();
   endtask

   task automatic wipe(input string tag);
      err_clr = ef;
      ef = '0;
      expect_out(ef, 1'b0, tag);
      fire();
   endtask

   // monitor: compares a quarter cycle after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         pcnt++;
         #5;
         while (q_at.size() > 0 && q_at[0] == pcnt) begin
            logic [6:0] f;
            logic c;
            string t;
            void'(q_at.pop_front());
            f = q_f.pop_front();
            c = q_c.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (err_flags !== f || cancel !== c || irq !== (|f)) begin
               errors++;
               $display("FAIL %s: flags=%b cancel=%b irq=%b expected flags=%b cancel=%b irq=%b",
                        t, err_flags, cancel, irq, f, c, |f);
            end
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual hung, expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      quiet();
      phase = P_IDLE; tx_active = 0; tx_bit = 1; rx_bit = 1; rx_byte = '0;
      brk_len = '0; brk_thr = 5'd10; dlen = '0; cks_enh = 0; cks_ok = 1;
      resp_rdy = 1; err_en = 7'h7F;
      repeat (3) @(negedge clk);
      rst_n = 1;
      expect_out(ef, 0, "R1 reset state");
      fire();

      // R2/R4: gap bit error
      tx_active = 1; phase = P_GAP; bit_stb = 1; tx_bit = 1; rx_bit = 0;
      ef[0] = 1; expect_out(ef, 1, "R2 R4 gap bit error flags and cuts");
      fire();
      expect_out(ef, 0, "R4 cancel is one cycle");
      fire();
      wipe("R12 clear bit error");

      // R3: data bit error waits for stop bit
      phase = P_DATA; bit_stb = 1; tx_bit = 0; rx_bit = 1;
      ef[0] = 1; expect_out(ef, 0, "R3 no cancel inside data byte");
      fire();
      for (int i = 0; i < 3; i++) begin
         phase = P_DATA; bit_stb = 1; tx_bit = 1; rx_bit = 1;
         expect_out(ef, 0, "R3 still no cancel before stop");
         fire();
      end
      phase = P_STOP; bit_stb = 1; tx_bit = 1; rx_bit = 1;
      expect_out(ef, 1, "R3 cancel after stop bit");
      fire();
      expect_out(ef, 0, "R3 cancel pulse ends");
      fire();
      wipe("R12 clear after R3");

      // R4: wake pulse bit error
      phase = P_WAKE; bit_stb = 1; tx_bit = 0; rx_bit = 1;
      ef[0] = 1; expect_out(ef, 1, "R4 wake bit error cuts");
      fire();
      wipe("R12 clear after R4");

      // R5: framing
      tx_active = 0; phase = P_STOP; bit_stb = 1; rx_bit = 1;
      expect_out(ef, 0, "R5 high stop bit accepted");
      fire();
      phase = P_STOP; bit_stb = 1; rx_bit = 0;
      ef[2] = 1; expect_out(ef, 1, "R5 R11 low stop bit flags and cuts");
      fire();
      wipe("R12 clear framing");
      rx_bit = 1;

      // R6: sync field
      phase = P_SYNC; byte_stb = 1; brk_len = 5'd11; rx_byte = 8'h55;
      expect_out(ef, 0, "R6 correct sync after long break");
      fire();
      phase = P_SYNC; byte_stb = 1; brk_len = 5'd10; rx_byte = 8'h00;
      expect_out(ef, 0, "R6 bad sync after break at threshold");
      fire();
      phase = P_SYNC; byte_stb = 1; brk_len = 5'd11; rx_byte = 8'h54;
      ef[3] = 1; expect_out(ef, 1, "R6 bad sync after long break");
      fire();
      wipe("R12 clear sync");

      // R7: identifier parity
      phase = P_PID; byte_stb = 1; rx_byte = pid_of(6'h3C);
      expect_out(ef, 0, "R7 good parity id 0x3C");
      fire();
      phase = P_PID; byte_stb = 1; rx_byte = pid_of(6'h01);
      expect_out(ef, 0, "R7 good parity id 0x01");
      fire();
      phase = P_PID; byte_stb = 1; rx_byte = pid_of(6'h01) ^ 8'h80;
      ef[5] = 1; expect_out(ef, 1, "R7 wrong P1 flags");
      fire();
      wipe("R12 clear parity");
      phase = P_PID; byte_stb = 1; rx_byte = pid_of(6'h3C) ^ 8'h40;
      ef[5] = 1; expect_out(ef, 1, "R7 wrong P0 flags");
      fire();
      wipe("R12 clear parity again");

      // R8: timeout, classic, no data: 63 strobes
      phase = P_IDLE; frame_start = 1; dlen = 4'd0; cks_enh = 0;
      fire();
      for (int i = 1; i <= 63; i++) begin
         bit_stb = 1;
         if (i == 62) expect_out(ef, 0, "R8 classic one strobe short");
         if (i == 63) begin ef[1] = 1; expect_out(ef, 1, "R8 classic timeout at 63"); end
         fire();
      end
      wipe("R12 clear timeout");

      // R8: enhanced, two bytes: limit 90, ended at 89
      frame_start = 1; dlen = 4'd2; cks_enh = 1;
      fire();
      for (int i = 1; i <= 89; i++) begin
         bit_stb = 1;
         fire();
      end
      frame_end = 1;
      fire();
      for (int i = 0; i < 5; i++) begin
         bit_stb = 1;
         expect_out(ef, 0, "R8 frame end stops timer");
         fire();
      end

      // R9, R10 with enables off
      err_en = '0;
      cks_stb = 1; cks_ok = 0;
      ef[4] = 1; expect_out(ef, 0, "R9 checksum flags without cancel");
      fire();
      cks_ok = 1;
      resp_start = 1; resp_rdy = 1;
      expect_out(ef, 0, "R10 ready response no flag");
      fire();
      resp_start = 1; resp_rdy = 0;
      ef[6] = 1; expect_out(ef, 0, "R10 late response flags without cancel");
      fire();
      resp_rdy = 1;

      // R11: disabled errors ignored
      tx_active = 1; phase = P_GAP; bit_stb = 1; tx_bit = 1; rx_bit = 0;
      expect_out(ef, 0, "R11 disabled bit error ignored");
      fire();
      tx_active = 0; phase = P_STOP; bit_stb = 1; rx_bit = 0;
      expect_out(ef, 0, "R11 disabled framing ignored");
      fire();
      phase = P_SYNC; byte_stb = 1; brk_len = 5'd20; rx_byte = 8'hAA;
      expect_out(ef, 0, "R11 disabled sync ignored");
      fire();
      rx_bit = 1; phase = P_IDLE;

      // R12: clear of other bits, set wins over clear
      err_clr = 7'b0001111;
      expect_out(ef, 0, "R12 unrelated clear keeps flags");
      fire();
      cks_stb = 1; cks_ok = 0; err_clr = 7'b0010000;
      expect_out(ef, 0, "R12 set wins over clear");
      fire();
      cks_ok = 1;
      err_clr = 7'b0010000; ef[4] = 0;
      expect_out(ef, 0, "R12 clear drops checksum flag");
      fire();
      wipe("R1 R12 all cleared irq low");

      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule